// File: doc/BRIEF.md
# Aligned Per-Period Pulse Width Modulator

This block turns a 6-bit width code into one high pulse per pixel period. A pixel period is 64 cycles of a fast clock. A one-cycle strobe marks each period boundary. Each period the block can place the pulse at the start of the period, at the end, or in the middle. The choice comes from two control inputs that are sampled together with the code. Code and controls are taken in at the strobe edge and shape the period that begins right after that edge. The pulse for a given input set therefore appears one period after the inputs are presented.

A force input drives the output high with no clock involved, and it overrides the pulse logic. A synchronous active-low reset clears the captured code, so the output stays low until the first capture. The block suits printer-style gray-scale and edge placement, where width and position change from one pixel to the next.

Top module: `aligned_pwm`

## Requirements
- R1: Each period is 64 ticks. Tick 0 is the first cycle after the capture edge. The number of high ticks in a period is 0 for code 0 and code+1 for any other code, so 0x0F gives 16, 0x1F gives 32, 0x2F gives 48 and 0x3F gives 64. The high ticks form one contiguous run.
- R2: Code 0x3F holds the output high for the whole period, and code 0x00 holds it low for the whole period. Both results hold for all four combinations of `single_edge` and `trail_end`.
- R3: With `single_edge`=1 and `trail_end`=0 (left alignment), a nonzero pulse starts at tick 0.
- R4: With `single_edge`=1 and `trail_end`=1 (right alignment), a nonzero pulse ends on tick 63, so it starts at tick 64-width.
- R5: With `single_edge`=0 (centre alignment, `trail_end` has no effect), the pulse starts at tick floor((64-width)/2). When the low slack is odd, the extra low tick falls after the pulse.
- R6: `code_in`, `single_edge` and `trail_end` are sampled only at a rising edge where `period_start`=1. That edge restarts the tick count at 0. Changes to these inputs at any other edge do not alter the running period.
- R7: While `force_high`=1 the output is 1 at once, with no clock edge needed, and it stays 1 across clock edges. While `force_high`=0 the output follows the pulse logic.
- R8: Reset is synchronous and active low (`rst_n`=0). It clears the captured code to 0 and the tick count to 0. The output is low during reset and stays low after reset until the first capture, including when reset is applied in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_start | input | 1 | One-cycle strobe that captures the inputs and starts a period |
| code_in | input | 6 | Pulse width code |
| single_edge | input | 1 | 1: pulse aligned to one end of the period; 0: centred |
| trail_end | input | 1 | With single_edge=1, 1 aligns the pulse to the period end and 0 to the period start |
| force_high | input | 1 | Asynchronous override that drives the output high |
| pwm_out | output | 1 | Pulse output |

## Verification
The bench runs every code in each of the three alignments. For each period it measures the high-tick count, the first high tick and the number of rising transitions. This separates width errors from placement errors and from split pulses. The 0x00 and 0x3F codes are run under all four control combinations to show that alignment has no effect at the extremes. A centre run with `trail_end`=1 shows that this bit is ignored in centre mode. Odd-slack codes expose any rounding that places the extra tick on the wrong side.

Random inputs are driven during each period, which separates true boundary capture from a level-sensitive latch. Seeded random periods are mixed in. The force input is checked mid-cycle, across a clock edge, and after release. A reset in the middle of a period checks that the output goes low at once and that nothing stale survives the reset.

// File: rtl/apwm_pkg.sv
// Shared types for the aligned pulse width modulator.
// Assumes: alignment is chosen per period from two control bits.
package apwm_pkg;

    typedef enum logic [1:0] {
        ALIGN_LEFT   = 2'd0,
        ALIGN_RIGHT  = 2'd1,
        ALIGN_CENTRE = 2'd2
    } align_e;

    // Map the two control bits to an alignment; centre ignores trail.
    function automatic align_e align_from(input logic single, input logic trail);
        if (!single)
            return ALIGN_CENTRE;
        return trail ? ALIGN_RIGHT : ALIGN_LEFT;
    endfunction

endpackage

// File: rtl/apwm_latch.sv
// Period-boundary capture of the width code and the alignment.
// Assumes: capture is a one-cycle strobe; reset is synchronous, active low.
module apwm_latch
    import apwm_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    input  logic              single_edge,
    input  logic              trail_end,
    output logic [CODE_W-1:0] code_q,
    output align_e            align_q
);

    // Hold code and alignment; load them only on the boundary strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            align_q <= ALIGN_LEFT;
        end else if (capture) begin
            code_q  <= code_in;
            align_q <= align_from(single_edge, trail_end);
        end
    end

    // R6: a strobe loads the presented code
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (code_q == $past(code_in)));

    // R6: without a strobe the code is held
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(code_q));

    // R8: leaving reset, the captured code is zero
    a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (code_q == '0));

endmodule

// File: rtl/apwm_timebase.sv
// Tick counter for one pixel period, restarted by the boundary strobe.
// Assumes: the period is 2**CODE_W ticks, so the counter wraps naturally.
module apwm_timebase #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic [CODE_W-1:0] tick
);

    // Count ticks within the period; a strobe returns the count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick <= '0;
        else if (restart)
            tick <= '0;
        else
            tick <= tick + 1'b1;
    end

    // R6: the tick after a strobe is tick 0
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tick == '0));

    // R1: ticks advance by one between strobes
    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (tick == CODE_W'($past(tick) + 1'b1)));

endmodule

// File: rtl/apwm_window.sv
// Decodes width and start tick from the captured code and alignment, and
// flags whether the current tick lies inside the pulse window.
// Assumes: the window [start, start+width) fits within 2**CODE_W ticks.
module apwm_window
    import apwm_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] code,
    input  align_e            align,
    input  logic [CODE_W-1:0] tick,
    output logic              pulse
);

    localparam int CW     = CODE_W + 1;
    localparam int PERIOD = 1 << CODE_W;

    logic [CW-1:0] width;
    logic [CW-1:0] slack;
    logic [CW-1:0] start;
    logic [CW-1:0] stop;
    logic [CW-1:0] tick_x;

    // Width, placement and window compare for the running tick.
    always_comb begin
        width = (code == '0) ? '0 : (CW'(code) + CW'(1));
        slack = CW'(PERIOD) - width;
        case (align)
            ALIGN_LEFT:  start = '0;
            ALIGN_RIGHT: start = slack;
            default:     start = slack >> 1;
        endcase
        stop   = start + width;
        tick_x = CW'(tick);
        pulse  = (tick_x >= start) && (tick_x < stop);
    end

endmodule

// File: rtl/aligned_pwm.sv
// Top of the aligned per-period pulse width modulator: capture, tick
// timebase, window decode and the asynchronous force-high override.
// Assumes: period_start is driven once every 2**CODE_W clock cycles.
module aligned_pwm
    import apwm_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic [CODE_W-1:0] code_in,
    input  logic              single_edge,
    input  logic              trail_end,
    input  logic              force_high,
    output logic              pwm_out
);

    logic [CODE_W-1:0] code_q;
    align_e            align_q;
    logic [CODE_W-1:0] tick;
    logic              pulse;

    apwm_latch #(.CODE_W(CODE_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (period_start),
        .code_in     (code_in),
        .single_edge (single_edge),
        .trail_end   (trail_end),
        .code_q      (code_q),
        .align_q     (align_q)
    );

    apwm_timebase #(.CODE_W(CODE_W)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (period_start),
        .tick    (tick)
    );

    apwm_window #(.CODE_W(CODE_W)) u_window (
        .code  (code_q),
        .align (align_q),
        .tick  (tick),
        .pulse (pulse)
    );

    // Output: the override wins over the data path with no clock involved.
    always_comb pwm_out = force_high | pulse;

    // R2: full code keeps the output high
    a_r2_full: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '1) |-> pwm_out);

    // R2: zero code keeps the output low unless forced
    a_r2_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0 && !force_high) |-> !pwm_out);

    // R3: a left-aligned nonzero pulse is high on tick 0
    a_r3_left_start: assert property (@(posedge clk) disable iff (!rst_n)
        (align_q == ALIGN_LEFT && code_q != '0 && tick == '0) |-> pulse);

    // R4: a right-aligned nonzero pulse is high on the last tick
    a_r4_right_end: assert property (@(posedge clk) disable iff (!rst_n)
        (align_q == ALIGN_RIGHT && code_q != '0 && tick == '1) |-> pulse);

endmodule

// File: tb/aligned_pwm_tb.sv
module aligned_pwm_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       period_start = 1'b0;
    logic [5:0] code_in = '0;
    logic       single_edge = 1'b0;
    logic       trail_end = 1'b0;
    logic       force_high = 1'b0;
    logic       pwm_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    int  seed;

    aligned_pwm u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .code_in      (code_in),
        .single_edge  (single_edge),
        .trail_end    (trail_end),
        .force_high   (force_high),
        .pwm_out      (pwm_out)
    );

    always #5 clk = ~clk;

    function automatic int exp_width(input int code);
        return (code == 0) ? 0 : code + 1;
    endfunction

    function automatic int exp_start(input int code, input bit se, input bit te);
        int w;
        w = exp_width(code);
        if (!se) return (64 - w) / 2;
        if (te)  return 64 - w;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts at a negedge: present inputs with a strobe, run 64 ticks,
    // scramble the inputs during the period (R6), and end at a negedge.
    task automatic run_period(input int code, input bit se, input bit te, input string req);
        int cnt, first, rises, w, st;
        bit prev;
        cnt = 0; first = -1; rises = 0; prev = 1'b0;
        code_in = 6'(code); single_edge = se; trail_end = te; period_start = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (k == 0) begin
                period_start = 1'b0;
                code_in = 6'($urandom);
                single_edge = 1'($urandom);
                trail_end = 1'($urandom);
            end
            if (pwm_out) begin
                cnt++;
                if (first < 0) first = k;
                if (!prev) rises++;
            end
            prev = pwm_out;
        end
        w  = exp_width(code);
        st = exp_start(code, se, te);
        check(cnt == w, {req, " R1 width"}, cnt, w);
        check(w == 0 || first == st, {req, " start"}, first, st);
        check(rises == ((w > 0) ? 1 : 0), {req, " R1 single run"}, rises, (w > 0) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        seed = $urandom(32'h5eed);
        // R8: low during and after reset, before any capture
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R8 in reset", pwm_out, 0);
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(pwm_out == 1'b0, "R8 after reset", pwm_out, 0);
        end

        // R2: extremes under every control combination
        for (int c = 0; c < 4; c++) begin
            run_period(63, c[1], c[0], "R2 full");
            run_period(0, c[1], c[0], "R2 empty");
        end

        // R3 R4 R5: every code in each alignment
        for (int code = 0; code < 64; code++) begin
            run_period(code, 1'b1, 1'b0, "R3 left");
            run_period(code, 1'b1, 1'b1, "R4 right");
            run_period(code, 1'b0, 1'b0, "R5 centre");
        end
        // R5: trail_end ignored in centre mode
        for (int code = 1; code < 64; code += 7)
            run_period(code, 1'b0, 1'b1, "R5 centre trail=1");

        // R6: seeded random periods
        for (int i = 0; i < 60; i++) begin
            int rc;
            bit rs, rt;
            rc = int'($urandom % 64);
            rs = 1'($urandom);
            rt = 1'($urandom);
            run_period(rc, rs, rt, "R6 random");
        end

        // R7: asynchronous override during a zero-code period
        code_in = '0; single_edge = 1'b1; trail_end = 1'b0; period_start = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (k == 0) period_start = 1'b0;
            if (k == 10) begin
                #1 force_high = 1'b1;
                #1 check(pwm_out == 1'b1, "R7 async force", pwm_out, 1);
                @(posedge clk);
                #1 check(pwm_out == 1'b1, "R7 force across edge", pwm_out, 1);
            end
            if (k == 11) begin
                force_high = 1'b0;
                #1 check(pwm_out == 1'b0, "R7 release follows data", pwm_out, 0);
            end
        end

        // R8: reset in the middle of a full-code period
        code_in = 6'h3F; single_edge = 1'b1; trail_end = 1'b0; period_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        period_start = 1'b0;
        check(pwm_out == 1'b1, "R8 pre-reset full", pwm_out, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b0, "R8 mid-period reset", pwm_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check(pwm_out == 1'b0, "R8 stays low until capture", pwm_out, 0);

        // R6: capture resumes normally after reset
        run_period(31, 1'b1, 1'b1, "R6 after reset R4");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule